// File: doc/BRIEF.md
# Integer Divide Unit

The block is a 32-bit integer divider. It handles the four divide and remainder operations of a common RISC instruction set extension: signed quotient, unsigned quotient, signed remainder and unsigned remainder. A 2-bit opcode picks the operation. Operands are presented together with a valid strobe. The selected result comes out with its own valid flag after a fixed number of enabled clock cycles, and a parameter sets that number.

Internally the unit takes the magnitude of each operand and runs one unsigned restoring divider, which yields quotient and remainder together. It then puts the signs back and substitutes the architecturally fixed values for a zero divisor. It never traps. Results travel through a pipeline of `LATENCY` register stages. A depth of zero makes the unit purely combinational. The whole pipeline, valid bits included, advances only while the clock enable is high. An active-low asynchronous clear empties it.

Top module: `int_div_unit`

## Requirements
- R1: Opcode 2'b01 returns the unsigned quotient floor(num_i / den_i) of the two 32-bit operands taken as unsigned.
- R2: Opcode 2'b00 returns the signed quotient of the operands taken as two's complement, rounded toward zero.
- R3: Opcode 2'b10 returns the signed remainder, and opcode 2'b11 returns the unsigned remainder. A nonzero signed remainder has the sign of the dividend, and num = q*den + rem holds.
- R4: With den_i equal to 0, both quotient opcodes (2'b00 and 2'b01) return 32'hFFFF_FFFF.
- R5: With den_i equal to 0, both remainder opcodes (2'b10 and 2'b11) return num_i unchanged.
- R6: Signed quotient of 32'h8000_0000 by 32'hFFFF_FFFF returns 32'h8000_0000, and the signed remainder of the same pair returns 0.
- R7: valid_o rises with the matching result exactly LATENCY enabled clock edges after the edge that captured valid_i. Back-to-back operations, one per enabled cycle, leave in issue order.
- R8: While en_i is low, no pipeline stage changes. valid_o and result_o hold their values.
- R9: Driving rst_ni low clears every stage at once, without waiting for a clock edge. valid_o drops to 0, and operations in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| en_i | input | 1 | Clock enable for all pipeline stages |
| valid_i | input | 1 | Operation strobe, captured on an enabled edge |
| op_i | input | 2 | Operation: 00 signed div, 01 unsigned div, 10 signed rem, 11 unsigned rem |
| num_i | input | 32 | Dividend |
| den_i | input | 32 | Divisor |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Selected quotient or remainder |

## Verification
Two things can land in the same cycle: a result reaching the last stage, and the enable being dropped. The bench provokes this by pulling en_i low for several cycles while a stream of operations is still in flight, including stretches where en_i falls exactly as valid_o rises. The scoreboard counts only enabled edges when it predicts when each result will emerge. On held cycles it requires valid_o and result_o to stay frozen and pops nothing. A second collision is an asynchronous clear arriving while operations are in flight. The bench drives it mid-cycle and expects valid_o to fall before the next edge, with no stale result appearing afterwards.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  // op bit 0: unsigned representation, op bit 1: remainder select
  function automatic logic op_is_signed(input logic [1:0] op);
    return ~op[0];
  endfunction

  function automatic logic op_is_rem(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         is_signed_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  always_comb begin
    neg_o = is_signed_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int NW = 32,
  parameter int DW = 32
) (
  input  logic [NW-1:0] n_i,
  input  logic [DW-1:0] d_i,
  output logic [NW-1:0] q_o,
  output logic [DW-1:0] r_o
);
  // restoring array, one row per dividend bit
  logic [DW:0] acc;
  always_comb begin
    acc = '0;
    q_o = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      acc = {acc[DW-1:0], n_i[i]};
      if (acc >= {1'b0, d_i}) begin
        acc    = acc - {1'b0, d_i};
        q_o[i] = 1'b1;
      end
    end
    r_o = acc[DW-1:0];
  end
endmodule

// File: rtl/div_fixup.sv
module div_fixup
  import int_div_pkg::*;
#(
  parameter int NW = 32,
  parameter int DW = 32
) (
  input  logic [1:0]    op_i,
  input  logic [NW-1:0] num_i,
  input  logic          den_zero_i,
  input  logic          num_neg_i,
  input  logic          den_neg_i,
  input  logic [NW-1:0] q_mag_i,
  input  logic [DW-1:0] r_mag_i,
  output logic [NW-1:0] res_o
);
  logic [NW-1:0] q_s, r_ext, r_s;

  always_comb begin
    q_s   = (num_neg_i ^ den_neg_i) ? (~q_mag_i + NW'(1)) : q_mag_i;
    r_ext = '0;
    r_ext[DW-1:0] = r_mag_i;
    r_s   = num_neg_i ? (~r_ext + NW'(1)) : r_ext;
    if (op_is_rem(op_i)) res_o = den_zero_i ? num_i : r_s;
    else                 res_o = den_zero_i ? '1    : q_s;
  end
endmodule

// File: rtl/div_pipe.sv
module div_pipe #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (DEPTH == 0) begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end else begin : g_reg
    logic [W-1:0]     d_q [DEPTH];
    logic [DEPTH-1:0] v_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= '0;
        for (int i = 0; i < DEPTH; i++) d_q[i] <= '0;
      end else if (en_i) begin
        v_q[0] <= valid_i;
        d_q[0] <= data_i;
        for (int i = 1; i < DEPTH; i++) begin
          v_q[i] <= v_q[i-1];
          d_q[i] <= d_q[i-1];
        end
      end
    end

    assign valid_o = v_q[DEPTH-1];
    assign data_o  = d_q[DEPTH-1];
  end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import int_div_pkg::*;
#(
  parameter int NUM_W   = 32,
  parameter int DEN_W   = 32,
  parameter int LATENCY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [NUM_W-1:0] result_o
);
  localparam int RES_W = NUM_W;

  logic             sgn;
  logic [NUM_W-1:0] num_mag, q_mag;
  logic [DEN_W-1:0] den_mag, r_mag;
  logic             num_neg, den_neg, den_zero;
  logic [RES_W-1:0] res_c;

  assign sgn      = op_is_signed(op_i);
  assign den_zero = (den_i == '0);

  div_sign_prep #(.W(NUM_W)) u_num_prep (
    .val_i(num_i), .is_signed_i(sgn), .mag_o(num_mag), .neg_o(num_neg)
  );

  div_sign_prep #(.W(DEN_W)) u_den_prep (
    .val_i(den_i), .is_signed_i(sgn), .mag_o(den_mag), .neg_o(den_neg)
  );

  div_core #(.NW(NUM_W), .DW(DEN_W)) u_core (
    .n_i(num_mag), .d_i(den_mag), .q_o(q_mag), .r_o(r_mag)
  );

  div_fixup #(.NW(NUM_W), .DW(DEN_W)) u_fix (
    .op_i(op_i), .num_i(num_i), .den_zero_i(den_zero),
    .num_neg_i(num_neg), .den_neg_i(den_neg),
    .q_mag_i(q_mag), .r_mag_i(r_mag), .res_o(res_c)
  );

  div_pipe #(.W(RES_W), .DEPTH(LATENCY)) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .valid_i(valid_i), .data_i(res_c),
    .valid_o(valid_o), .data_o(result_o)
  );
endmodule

// File: rtl/int_div_unit_chk.sv
module int_div_unit_chk #(
  parameter int NUM_W   = 32,
  parameter int DEN_W   = 32,
  parameter int LATENCY = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic [NUM_W-1:0] num_i,
  input logic [DEN_W-1:0] den_i,
  input logic [NUM_W-1:0] res_c,
  input logic             valid_o,
  input logic [NUM_W-1:0] result_o
);
  localparam logic [NUM_W-1:0] MIN_NEG = {1'b1, {(NUM_W-1){1'b0}}};

  // R4
  a_r4_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && den_i == '0 && !op_i[1]) |-> (res_c == '1));

  // R5
  a_r5_rem_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && den_i == '0 && op_i[1]) |-> (res_c == num_i));

  // R6
  a_r6_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[0] && num_i == MIN_NEG && den_i == '1)
      |-> (res_c == (op_i[1] ? '0 : MIN_NEG)));

  // R3
  a_r3_rem_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && den_i != '0 && res_c != '0)
      |-> (res_c[NUM_W-1] == num_i[NUM_W-1]));

  if (LATENCY > 0) begin : g_seq
    // R8
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> ($stable(valid_o) && $stable(result_o)));
    // R9
    always @(negedge clk_i)
      if (!rst_ni) a_r9_clear: assert (valid_o == 1'b0);
  end

  if (LATENCY == 1) begin : g_one
    // R7
    a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> (valid_o == $past(valid_i)));
  end
endmodule

bind int_div_unit int_div_unit_chk #(
  .NUM_W(NUM_W), .DEN_W(DEN_W), .LATENCY(LATENCY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
  .op_i(op_i), .num_i(num_i), .den_i(den_i), .res_c(res_c),
  .valid_o(valid_o), .result_o(result_o)
);

// File: tb/int_div_unit_tb_top.sv
module int_div_unit_tb_top;
  localparam int CLK_P   = 10;
  localparam int LAT     = 2;
  localparam int WD_CYC  = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] num_i = '0;
  logic [31:0] den_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  int ecnt   = 0;

  logic [31:0] q_res [$];
  int          q_due [$];
  string       q_tag [$];

  logic        prev_v;
  logic [31:0] prev_r;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_P/2) clk_i = ~clk_i;

  int_div_unit #(.NUM_W(32), .DEN_W(32), .LATENCY(LAT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
    .op_i(op_i), .num_i(num_i), .den_i(den_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  always @(posedge clk_i) if (rst_ni && en_i) ecnt <= ecnt + 1;

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic ovf;
    ovf = (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
    case (op)
      2'b01: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      2'b11: return (b == 0) ? a : a % b;
      2'b00: return (b == 0) ? 32'hFFFF_FFFF : ovf ? 32'h8000_0000 : 32'($signed(a) / $signed(b));
      default: return (b == 0) ? a : ovf ? 32'h0 : 32'($signed(a) % $signed(b));
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (b == 0) return op[1] ? "R5" : "R4";
    if (!op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R6";
    if (op == 2'b01) return "R1";
    if (op == 2'b00) return "R2";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    en_i = 1'b1; valid_i = 1'b1; op_i = op; num_i = a; den_i = b;
    q_res.push_back(model(op, a, b));
    q_due.push_back(ecnt + LAT);
    q_tag.push_back(tag_of(op, a, b));
  endtask

  task automatic idle(input int n, input logic en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; en_i = en;
    end
  endtask

  // monitor: sample just after each edge
  initial begin
    prev_v = 1'b0; prev_r = '0;
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni) begin
        if (!en_i) begin
          check(valid_o == prev_v, "R8", "valid held", 32'(valid_o), 32'(prev_v));
          check(result_o == prev_r, "R8", "result held", result_o, prev_r);
        end else if (valid_o) begin
          if (q_res.size() == 0) begin
            check(1'b0, "R7", "unexpected valid", result_o, 32'h0);
          end else begin
            logic [31:0] er; int ed; string et;
            er = q_res.pop_front(); ed = q_due.pop_front(); et = q_tag.pop_front();
            check(result_o == er, et, "result", result_o, er);
            check(ecnt == ed, "R7", "latency", 32'(ecnt), 32'(ed));
          end
        end
        prev_v = valid_o; prev_r = result_o;
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R9", "reset valid", 32'(valid_o), 32'h0);
    rst_ni = 1'b1;
    // R1 unsigned quotient
    issue(2'b01, 32'd100, 32'd7);
    issue(2'b01, 32'hFFFF_FFFF, 32'd3);
    issue(2'b01, 32'h8000_0000, 32'hFFFF_FFFF);
    // R2 signed quotient, truncation toward zero
    issue(2'b00, 32'd7, -32'sd2);
    issue(2'b00, -32'sd7, 32'd2);
    issue(2'b00, -32'sd7, -32'sd2);
    // R3 remainders
    issue(2'b10, -32'sd7, 32'd2);
    issue(2'b10, 32'd7, -32'sd2);
    issue(2'b11, 32'hFFFF_FFFF, 32'd10);
    // R4 / R5 zero divisor
    issue(2'b00, 32'h1234_5678, 32'd0);
    issue(2'b01, 32'h0, 32'd0);
    issue(2'b10, 32'h8765_4321, 32'd0);
    issue(2'b11, 32'hDEAD_BEEF, 32'd0);
    // R6 overflow
    issue(2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
    issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    idle(LAT + 2, 1'b1);
    // R8 hold while in flight and as result emerges
    issue(2'b01, 32'd50, 32'd5);
    issue(2'b00, -32'sd50, 32'd5);
    idle(3, 1'b0);
    idle(1, 1'b1);
    idle(4, 1'b0);
    idle(LAT + 2, 1'b1);
    // mixed stream with random holds
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg;
      if (k % 11 == 0) b = 32'd0;
      else if (k % 5 == 0) b = b >> (k % 29);
      issue(2'(k), a, b);
      if (lcg[7:5] == 3'b000) idle(int'(lcg[1:0]) + 1, 1'b0);
    end
    idle(LAT + 3, 1'b1);
    check(q_res.size() == 0, "R7", "drained", 32'(q_res.size()), 32'h0);
    // R9 asynchronous clear with work in flight
    issue(2'b01, 32'd9, 32'd3);
    issue(2'b01, 32'd8, 32'd2);
    @(posedge clk_i);
    #(CLK_P/4);
    rst_ni = 1'b0;
    #1;
    check(valid_o == 1'b0, "R9", "async clear", 32'(valid_o), 32'h0);
    q_res.delete(); q_due.delete(); q_tag.delete();
    idle(2, 1'b1);
    rst_ni = 1'b1;
    idle(LAT + 2, 1'b1);
    check(valid_o == 1'b0, "R9", "no stale result", 32'(valid_o), 32'h0);
    issue(2'b11, 32'd23, 32'd5);
    idle(LAT + 2, 1'b1);
    check(q_res.size() == 0, "R9", "work after clear", 32'(q_res.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule